// File: doc/BRIEF.md
# Page-Attribute and Range-Type Memory Type Combiner

This block decides the effective memory type of a 4 KB page. It does this by merging two inputs. The first is the type chosen by the page-table entry through a 64-bit page attribute register. The second is the memory type that a range lookup elsewhere in the chip has already produced. The register holds eight one-byte type slots. Three attribute bits from the page-table entry form a 3-bit slot index, and the byte that index selects is the page type. The page type and the range type then go through a fixed precedence matrix, which yields the effective type. This path is purely combinational.

Software updates the attribute register through a single-cycle valid/data write port. The block checks every byte of the write word. If any byte holds an illegal code, the whole write is refused, the register keeps its old contents, and an error strobe rises in the same cycle. A write that passes the check is visible from the next rising clock edge.

Type codes are UC=0, WC=1, WT=4, WP=5, WB=6 and UC-minus=7. Codes 2 and 3 are reserved.

Top module: `pat_mtrr_combiner`

## Requirements
- R1: After reset the attribute register reads, from slot 0 upward, WB, WT, UC-minus, UC, WB, WT, UC-minus, UC, which is the value 64'h0007040600070406.
- R2: The slot index is {pte_pat, pte_pcd, pte_pwt}, with pte_pwt as bit 0 and pte_pat as bit 2. `page_type` shows register bits 8n+7 down to 8n for index n.
- R3: For range type UC, a page type of WC gives WC, and every other legal page type gives UC.
- R4: For range type WC, page UC or WT or WP gives UC, and page WC or WB or UC-minus gives WC.
- R5: For range type WT, page UC gives UC, WC gives WC, WT gives WT, WP gives WP, WB gives WT and UC-minus gives UC.
- R6: For range type WP, page UC gives UC, WC gives WC, WT gives WT, WP gives WP, WB gives WP and UC-minus gives WC.
- R7: For range type WB, every legal page type passes through unchanged, except that UC-minus becomes UC. Only this range type can yield WB.
- R8: A reserved range type (2, 3 or 7) or a reserved page type (2 or 3) gives the reserved result 2.
- R9: A write with `wr_valid` high in which every byte is in {0,1,4,5,6,7} loads the register at that clock edge. When `wr_valid` is low the register holds.
- R10: A write with `wr_valid` high in which any byte lies outside {0,1,4,5,6,7} raises `wr_err` in the same cycle and leaves the register unchanged. `wr_err` is never high while `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write word, eight type bytes |
| wr_err | output | 1 | Write refused (illegal byte), same cycle |
| pte_pat | input | 1 | Page-table attribute bit, index bit 2 |
| pte_pcd | input | 1 | Page-table cache-disable bit, index bit 1 |
| pte_pwt | input | 1 | Page-table write-through bit, index bit 0 |
| range_type | input | 3 | Memory type from the range lookup |
| page_type | output | 8 | Selected register byte |
| eff_type | output | 3 | Effective memory type |

## Verification
`page_type`, `eff_type` and `wr_err` are combinational, so they are due in the same cycle as their inputs. The bench drives inputs on the falling edge and samples them 1 ns later, well before the next rising edge. A register write lands on the rising edge that follows the falling edge on which it is driven. Every lookup that depends on a write is therefore issued at a later falling edge. A scoreboard queue carries each expected lookup result from the driver to the monitor, and the monitor compares it when the driver signals that the sample point has been reached.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

  // Type codes shared by the register, the decoder and the combining matrix.
  localparam logic [2:0] MT_UC   = 3'd0;
  localparam logic [2:0] MT_WC   = 3'd1;
  localparam logic [2:0] MT_RSV  = 3'd2;
  localparam logic [2:0] MT_RSV3 = 3'd3;
  localparam logic [2:0] MT_WT   = 3'd4;
  localparam logic [2:0] MT_WP   = 3'd5;
  localparam logic [2:0] MT_WB   = 3'd6;
  localparam logic [2:0] MT_UCM  = 3'd7;

  localparam int unsigned SLOT_W  = 8;
  localparam int unsigned NSLOTS  = 8;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned ATTR_W  = SLOT_W * NSLOTS;

  // Slots 0..7: WB, WT, UC-, UC repeated.
  localparam logic [63:0] ATTR_RESET = 64'h0007040600070406;

  // A slot value may hold any non-reserved code, UC-minus included.
  function automatic logic slot_legal(input logic [SLOT_W-1:0] v);
    logic hi_zero;
    hi_zero = (v[SLOT_W-1:3] == '0);
    return hi_zero && (v[2:0] != MT_RSV) && (v[2:0] != MT_RSV3);
  endfunction

endpackage

// File: rtl/attr_store.sv
module attr_store
  import memtype_pkg::*;
#(
  parameter int unsigned W_SLOT = SLOT_W,
  parameter int unsigned N_SLOT = NSLOTS,
  parameter logic [W_SLOT*N_SLOT-1:0] RST_VAL = ATTR_RESET
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [W_SLOT*N_SLOT-1:0] wr_data,
  output logic                     wr_err,
  output logic [W_SLOT*N_SLOT-1:0] attr_q
);
  localparam int unsigned REG_W = W_SLOT * N_SLOT;

  logic [N_SLOT-1:0] slot_ok;
  logic              any_bad;
  logic              load_en;
  logic [REG_W-1:0]  attr_d;

  // One legality checker per slot.
  for (genvar g = 0; g < N_SLOT; g++) begin : g_check
    assign slot_ok[g] = slot_legal(wr_data[g*W_SLOT +: W_SLOT]);
  end

  assign any_bad = ~(&slot_ok);
  assign load_en = wr_valid & ~any_bad;
  assign wr_err  = wr_valid & any_bad;

  always_comb begin
    attr_d = attr_q;
    if (load_en) begin
      attr_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= RST_VAL;
    end else if (load_en) begin
      attr_q <= attr_d;
    end
  end

endmodule

// File: rtl/attr_index_sel.sv
module attr_index_sel
  import memtype_pkg::*;
#(
  parameter int unsigned W_SLOT = SLOT_W,
  parameter int unsigned N_SLOT = NSLOTS
) (
  input  logic                     pte_pat,
  input  logic                     pte_pcd,
  input  logic                     pte_pwt,
  input  logic [W_SLOT*N_SLOT-1:0] attr,
  output logic [W_SLOT-1:0]        slot_val
);
  logic [IDX_W-1:0]  idx;
  logic [W_SLOT-1:0] slots [N_SLOT];

  // Index: write-through bit lowest, attribute bit highest.
  assign idx = {pte_pat, pte_pcd, pte_pwt};

  for (genvar g = 0; g < N_SLOT; g++) begin : g_split
    assign slots[g] = attr[g*W_SLOT +: W_SLOT];
  end

  assign slot_val = slots[idx];

endmodule

// File: rtl/type_combine.sv
module type_combine
  import memtype_pkg::*;
#(
  parameter int unsigned W_SLOT = SLOT_W
) (
  input  logic [2:0]        range_type,
  input  logic [W_SLOT-1:0] page_byte,
  output logic [2:0]        eff
);
  logic       page_rsv;
  logic       range_rsv;
  logic [2:0] pt;

  assign pt        = page_byte[2:0];
  assign page_rsv  = ~slot_legal(page_byte);
  assign range_rsv = (range_type == MT_RSV) || (range_type == MT_RSV3) ||
                     (range_type == MT_UCM);

  always_comb begin
    eff = MT_RSV;
    if (!page_rsv && !range_rsv) begin
      case (range_type)
        MT_UC: eff = (pt == MT_WC) ? MT_WC : MT_UC;
        MT_WC: begin
          case (pt)
            MT_WC, MT_WB, MT_UCM: eff = MT_WC;
            default:              eff = MT_UC;
          endcase
        end
        MT_WT: begin
          case (pt)
            MT_WC:        eff = MT_WC;
            MT_WT, MT_WB: eff = MT_WT;
            MT_WP:        eff = MT_WP;
            default:      eff = MT_UC;
          endcase
        end
        MT_WP: begin
          case (pt)
            MT_WC, MT_UCM: eff = MT_WC;
            MT_WT:         eff = MT_WT;
            MT_WP, MT_WB:  eff = MT_WP;
            default:       eff = MT_UC;
          endcase
        end
        MT_WB:   eff = (pt == MT_UCM) ? MT_UC : pt;
        default: eff = MT_RSV;
      endcase
    end
  end

endmodule

// File: rtl/pat_mtrr_combiner.sv
module pat_mtrr_combiner
  import memtype_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [63:0] wr_data,
  output logic        wr_err,
  input  logic        pte_pat,
  input  logic        pte_pcd,
  input  logic        pte_pwt,
  input  logic [2:0]  range_type,
  output logic [7:0]  page_type,
  output logic [2:0]  eff_type
);
  logic [ATTR_W-1:0] attr_q;

  attr_store #(
    .W_SLOT (SLOT_W),
    .N_SLOT (NSLOTS),
    .RST_VAL(ATTR_RESET)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_data (wr_data),
    .wr_err  (wr_err),
    .attr_q  (attr_q)
  );

  attr_index_sel #(
    .W_SLOT(SLOT_W),
    .N_SLOT(NSLOTS)
  ) u_sel (
    .pte_pat (pte_pat),
    .pte_pcd (pte_pcd),
    .pte_pwt (pte_pwt),
    .attr    (attr_q),
    .slot_val(page_type)
  );

  type_combine #(
    .W_SLOT(SLOT_W)
  ) u_comb (
    .range_type(range_type),
    .page_byte (page_type),
    .eff       (eff_type)
  );

endmodule

// File: rtl/pat_mtrr_combiner_chk.sv
module pat_mtrr_combiner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [63:0] wr_data,
  input logic        wr_err,
  input logic [2:0]  range_type,
  input logic [2:0]  eff_type,
  input logic [63:0] attr_q
);

  assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> wr_valid);

  assert_reject_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> attr_q == $past(attr_q));

  assert_accept_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_err) |=> attr_q == $past(wr_data));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(attr_q));

  assert_rsv_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (range_type == 3'd2 || range_type == 3'd3 || range_type == 3'd7) |-> eff_type == 3'd2);

  assert_wb_only_from_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_type == 3'd6) |-> range_type == 3'd6);

  assert_uc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_type == 3'd0) |-> (eff_type == 3'd0 || eff_type == 3'd1));

endmodule

bind pat_mtrr_combiner pat_mtrr_combiner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .wr_err    (wr_err),
  .range_type(range_type),
  .eff_type  (eff_type),
  .attr_q    (attr_q)
);

// File: tb/sim_pat_mtrr_combiner.sv
`timescale 1ns/1ps
module sim_pat_mtrr_combiner;
  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic        wr_err;
  logic        pte_pat, pte_pcd, pte_pwt;
  logic [2:0]  range_type;
  logic [7:0]  page_type;
  logic [2:0]  eff_type;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] model_reg;

  logic [7:0] exp_page_q [$];
  logic [2:0] exp_eff_q  [$];
  string      tag_q      [$];
  event       sample_ev;

  pat_mtrr_combiner u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_err(wr_err), .pte_pat(pte_pat), .pte_pcd(pte_pcd), .pte_pwt(pte_pwt),
    .range_type(range_type), .page_type(page_type), .eff_type(eff_type)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected effective type, written from the requirement text.
  function automatic logic [2:0] model_eff(input logic [2:0] rt, input logic [7:0] pb);
    logic [2:0] p;
    p = pb[2:0];
    if (pb > 8'd7 || p == 3'd2 || p == 3'd3) return 3'd2;         // R8
    if (rt == 3'd2 || rt == 3'd3 || rt == 3'd7) return 3'd2;      // R8
    if (p == 3'd0) return 3'd0;
    if (p == 3'd1) return 3'd1;
    if (rt == 3'd0) return 3'd0;                                  // R3
    if (rt == 3'd1) return (p == 3'd6 || p == 3'd7) ? 3'd1 : 3'd0; // R4
    if (rt == 3'd4) begin                                         // R5
      if (p == 3'd6) return 3'd4;
      if (p == 3'd7) return 3'd0;
      return p;
    end
    if (rt == 3'd5) begin                                         // R6
      if (p == 3'd6) return 3'd5;
      if (p == 3'd7) return 3'd1;
      return p;
    end
    return (p == 3'd7) ? 3'd0 : p;                                // R7
  endfunction

  function automatic string row_tag(input logic [2:0] rt);
    case (rt)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: apply a lookup on the falling edge and queue the expected result.
  task automatic do_lookup(input int idx, input logic [2:0] rt, input string tag);
    logic [7:0] pb;
    @(negedge clk);
    {pte_pat, pte_pcd, pte_pwt} = idx[2:0];
    range_type = rt;
    pb = model_reg[idx*8 +: 8];
    #1;
    exp_page_q.push_back(pb);
    exp_eff_q.push_back(model_eff(rt, pb));
    tag_q.push_back(tag);
    -> sample_ev;
  endtask

  task automatic do_write(input logic [63:0] d, input logic valid, input logic exp_err,
                          input string tag);
    @(negedge clk);
    wr_valid = valid;
    wr_data  = d;
    #1;
    n_checks++;
    if (wr_err !== exp_err) begin
      n_fail++;
      $display("FAIL %s wr_err actual=%0b expected=%0b", tag, wr_err, exp_err);
    end
    if (valid && !exp_err) model_reg = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = '0;
  endtask

  // Monitor: compare each queued expectation at the sample point.
  initial begin
    forever begin
      @(sample_ev);
      begin
        logic [7:0] ep;
        logic [2:0] ee;
        string t;
        ep = exp_page_q.pop_front();
        ee = exp_eff_q.pop_front();
        t  = tag_q.pop_front();
        n_checks++;
        if (page_type !== ep) begin
          n_fail++;
          $display("FAIL R2/%s page_type actual=%0h expected=%0h", t, page_type, ep);
        end
        n_checks++;
        if (eff_type !== ee) begin
          n_fail++;
          $display("FAIL %s eff_type actual=%0d expected=%0d", t, eff_type, ee);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_data = '0;
    pte_pat = 1'b0; pte_pcd = 1'b0; pte_pwt = 1'b0;
    range_type = 3'd6;
    model_reg = 64'h0007040600070406;   // R1 reset value
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset contents seen through every index with range WB.
    for (int i = 0; i < 8; i++) do_lookup(i, 3'd6, "R1");

    // R9: legal write covering every legal code.
    do_write(64'h0100070605040100, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 8; i++) do_lookup(i, 3'd6, "R9");

    // R3..R8: full sweep of indices against every range type.
    for (int rt = 0; rt < 8; rt++)
      for (int i = 0; i < 8; i++) do_lookup(i, rt[2:0], row_tag(rt[2:0]));

    // R10: illegal bytes refused, register unchanged.
    do_write(64'h0100070602040100, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 8; i++) do_lookup(i, 3'd6, "R10");
    do_write(64'h0800070605040100, 1'b1, 1'b1, "R10");
    do_lookup(7, 3'd6, "R10");
    do_write(64'h01000706050401FF, 1'b1, 1'b1, "R10");
    do_lookup(0, 3'd4, "R10");
    do_write(64'h0100070605040103, 1'b1, 1'b1, "R10");
    do_lookup(0, 3'd1, "R10");

    // R9 / R10: bad data without the strobe has no effect and no error.
    do_write(64'h0202020202020202, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 8; i++) do_lookup(i, 3'd5, "R9");

    // R9: second legal write, all UC-minus, then all WC.
    do_write(64'h0707070707070707, 1'b1, 1'b0, "R9");
    for (int rt = 0; rt < 8; rt++) do_lookup(rt, rt[2:0], row_tag(rt[2:0]));
    do_write(64'h0101010101010101, 1'b1, 1'b0, "R9");
    for (int rt = 0; rt < 8; rt++) do_lookup(7 - rt, rt[2:0], row_tag(rt[2:0]));

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule